// File: doc/BRIEF.md
# Device Search Direction Step

This block carries out a single decision step of the binary-tree search used to enumerate devices that share a single-wire bus. After a start strobe it asks an external bit-slot engine for two read slots in a row. The first returns the true bit that all still-active devices hold at the current position. The second returns the inverted copy of that bit. From the two values and a requested direction it picks the branch to follow. It then asks for one write slot that sends the chosen bit back, so that devices on the other branch drop out.

The slot engine is reached through a request/acknowledge pair. The block holds `slot_req` high, together with the slot kind and the write bit, until the engine pulses `slot_ack`. For a read slot, the engine returns the sampled bus level on `slot_rbit` in the same cycle as the acknowledge. When the step ends, `done` pulses for one cycle and `status` holds the packed result. Bit 0 is the true bit, bit 1 is the complement bit, and bit 2 is the direction taken. The search controller around this block keeps the position and the last-discrepancy state across steps.

Top module: `search_step`

## Requirements
- R1: After reset `slot_req`, `busy` and `done` are 0 and `status` is 3'b000.
- R2: A step begins with two read slots (`slot_wr`=0), the true bit first and then the complement bit. Any write slot (`slot_wr`=1) comes only after both reads.
- R3: When both read bits are 1, `status` is 3'b011 and no write slot is issued. `done` follows the acknowledge of the second read.
- R4: When both read bits are 0, the requested direction is taken. `status` is 3'b100 for direction 1 and 3'b000 for direction 0, and one write slot sends that direction on `slot_wbit`.
- R5: When exactly one read bit is 1, the direction is forced to the true bit. `status` is 3'b101 when the true bit is 1 and 3'b010 when it is 0, and the write slot sends the true bit.
- R6: `dir_req` is sampled in the cycle `start` is accepted. Later changes to it do not affect the step.
- R7: `done` is high for exactly one cycle. That cycle directly follows the acknowledge of the last slot of the step.
- R8: `start` is ignored while `busy` is high. Such a pulse starts no extra slots, either during or after the current step.
- R9: While a request is waiting for `slot_ack`, `slot_req`, `slot_wr` and `slot_wbit` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one search step |
| dir_req | input | 1 | Direction to take when both read bits are 0 |
| slot_req | output | 1 | Slot request to the bit-slot engine |
| slot_wr | output | 1 | Slot kind: 0 read, 1 write |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_ack | input | 1 | One-cycle slot completion pulse |
| slot_rbit | input | 1 | Sampled bus level, valid with `slot_ack` on a read |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle end-of-step pulse |
| status | output | 3 | {direction taken, complement bit, true bit} |

## Verification
The assertions check several properties on every cycle. A waiting request holds steady until its acknowledge. `done` never lasts more than one cycle and always follows an acknowledge. Any write slot carries the direction recorded in `status[2]`. Every completed step reports one of the five legal status codes. The bench's scenarios are needed for the rest. They show that the status code is the right one for each combination of read bits and requested direction, and that the error case issues no write. They also show that a direction change after start, or a second start during a step, leaves the result and the slot sequence unchanged. The bench covers every combination under several acknowledge latencies.

// File: rtl/search_step.sv
module search_step (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dir_req,
  output logic       slot_req,
  output logic       slot_wr,
  output logic       slot_wbit,
  input  logic       slot_ack,
  input  logic       slot_rbit,
  output logic       busy,
  output logic       done,
  output logic [2:0] status
);

  typedef enum logic [1:0] {S_IDLE, S_RD_TRUE, S_RD_CMP, S_WRITE} step_t;

  step_t      st;
  logic       dir_q;
  logic       true_q;
  logic       done_q;
  logic [2:0] stat_q;

  logic       both_one;
  logic       one_hot;
  logic       dir_pick;

  assign both_one = true_q & slot_rbit;
  assign one_hot  = true_q ^ slot_rbit;
  assign dir_pick = one_hot ? true_q : dir_q;

  assign busy      = (st != S_IDLE);
  assign slot_req  = busy;
  assign slot_wr   = (st == S_WRITE);
  assign slot_wbit = dir_q;
  assign done      = done_q;
  assign status    = stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dir_q  <= 1'b0;
      true_q <= 1'b0;
      done_q <= 1'b0;
      stat_q <= 3'b000;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            dir_q <= dir_req;
            st    <= S_RD_TRUE;
          end
        end
        S_RD_TRUE: begin
          if (slot_ack) begin
            true_q <= slot_rbit;
            st     <= S_RD_CMP;
          end
        end
        S_RD_CMP: begin
          if (slot_ack) begin
            if (both_one) begin
              stat_q <= 3'b011;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              dir_q  <= dir_pick;
              stat_q <= {dir_pick, slot_rbit, true_q};
              st     <= S_WRITE;
            end
          end
        end
        S_WRITE: begin
          if (slot_ack) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module search_step_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_req,
  input logic       slot_wr,
  input logic       slot_wbit,
  input logic       slot_ack,
  input logic       done,
  input logic [2:0] status
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_ack) |=> (slot_req && $stable(slot_wr) && $stable(slot_wbit)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(slot_ack));

  // R4
  write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && slot_wr) |-> (slot_wbit == status[2]));

  // R5
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status == 3'b000 || status == 3'b010 || status == 3'b011 ||
              status == 3'b100 || status == 3'b101));

endmodule

bind search_step search_step_chk u_chk (.*);

// File: tb/sim_search_step.sv
module sim_search_step;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       dir_req = 1'b0;
  logic       slot_ack = 1'b0;
  logic       slot_rbit = 1'b0;
  logic       slot_req, slot_wr, slot_wbit, busy, done;
  logic [2:0] status;

  int tests = 0;
  int fails = 0;

  int lat = 0;
  logic bit_true = 1'b0, bit_cmp = 1'b0;
  int n_rd = 0, n_wr = 0, wait_n = 0;
  logic wbit_seen = 1'b0;
  logic order_bad = 1'b0;

  always #10 clk = ~clk;

  search_step u0 (.*);

  task automatic check(input string req, input logic ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bit-slot engine model
  initial begin
    forever begin
      @(negedge clk);
      slot_ack = 1'b0;
      if (rst_n && slot_req) begin
        if (wait_n >= lat) begin
          wait_n = 0;
          slot_ack = 1'b1;
          if (!slot_wr) begin
            slot_rbit = (n_rd == 0) ? bit_true : bit_cmp;
            if (n_rd >= 2) order_bad = 1'b1;
            n_rd++;
          end else begin
            if (n_rd != 2) order_bad = 1'b1;
            wbit_seen = slot_wbit;
            n_wr++;
          end
        end else wait_n++;
      end
    end
  end

  task automatic run_step(input logic t, input logic c, input logic d, input int l, input logic extra);
    logic exp_dir;
    logic [2:0] exp_st;
    int guard;
    bit_true = t; bit_cmp = c; lat = l;
    n_rd = 0; n_wr = 0; wait_n = 0; order_bad = 1'b0; wbit_seen = 1'bx;
    @(negedge clk);
    start = 1'b1; dir_req = d;
    @(negedge clk);
    start = 1'b0; dir_req = ~d;  // R6: late change must not matter
    if (extra) begin
      @(negedge clk);
      start = 1'b1;               // R8: start while busy
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    check("R7 done seen", done, done, 1);
    if (t && c) begin
      exp_st = 3'b011;
      check("R3 status", status == exp_st, status, exp_st);
      check("R3 no write", n_wr == 0, n_wr, 0);
    end else begin
      exp_dir = (t ^ c) ? t : d;
      exp_st = {exp_dir, c, t};
      if (t ^ c) begin
        check("R5 status", status == exp_st, status, exp_st);
        check("R5 write bit", wbit_seen === exp_dir, wbit_seen, exp_dir);
      end else begin
        check("R4 R6 status", status == exp_st, status, exp_st);
        check("R4 R6 write bit", wbit_seen === exp_dir, wbit_seen, exp_dir);
      end
      check("R4 one write", n_wr == 1, n_wr, 1);
    end
    check("R2 two reads in order", n_rd == 2 && !order_bad, n_rd, 2);
    @(negedge clk);
    check("R7 done one cycle", !done, done, 0);
    if (extra) begin
      repeat (5) @(negedge clk);
      check("R8 no extra step", !slot_req && !busy && n_rd == 2, n_rd, 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req", slot_req == 0, slot_req, 0);
    check("R1 busy", busy == 0, busy, 0);
    check("R1 done", done == 0, done, 0);
    check("R1 status", status == 3'b000, status, 0);
    rst_n = 1'b1;
    for (int l = 0; l < 4; l += 1 + (l == 1)) begin
      for (int v = 0; v < 8; v++) begin
        run_step(v[0], v[1], v[2], l, 1'b0);
      end
    end
    for (int v = 0; v < 8; v++) run_step(v[0], v[1], v[2], 1, 1'b1);
    // R9: request must still be up while the engine is slow
    lat = 4; bit_true = 0; bit_cmp = 0; n_rd = 0; n_wr = 0; wait_n = 0;
    @(negedge clk); start = 1'b1; dir_req = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 req held", slot_req && !slot_wr && n_rd == 0, slot_req, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule